// File: doc/BRIEF.md
# Priority-Arbitrated Dual-Port Memory

This block is a small storage array with two independent access ports, A and B. Each port has its own enable, write strobe, address, write data, read data and a one-cycle "dropped" flag. Both ports may access the array in the same clock cycle. When they touch different words, or when both only read, both requests are served with no arbitration.

A collision needs arbitration when both ports are enabled, both carry the same address, and at least one of them writes. In that case a priority register picks one port. Only the chosen port's request reaches the array. The other port's request is thrown away whole: it writes nothing, it reads back zero, and its dropped flag pulses. The priority register flips after every collision it settles, so the two ports take turns winning. Port A wins the first collision after reset.

Every request is pipelined. It is captured on one rising edge, and its result appears on the port outputs after the following rising edge. The result stays for exactly one cycle.

Top module: `prio_dpram`

## Requirements
- R1: While reset is asserted, and after it is released, every stored word reads as zero and every read-data and dropped output is zero.
- R2: When both ports are enabled on different addresses, both requests are performed in that cycle (two writes, two reads, or one of each) and neither port is dropped.
- R3: When both ports read, both receive the stored word, whether the addresses match or not. Neither port is dropped, and the priority register does not change.
- R4: A collision is defined as: both ports enabled, equal addresses, and at least one write strobe high. In a collision only the winning port acts on the array. The losing port's write is not stored, its read data is zero, and its dropped flag is 1.
- R5: The priority register selects port A (value 0) after reset. It toggles after every collision, so winners alternate A, B, A, and so on.
- R6: In a read-write collision won by the reading port, the reader gets the value stored before that cycle, and the word keeps that value afterwards.
- R7: A request sampled on rising edge k shows its read data and dropped flag from edge k+1 until edge k+2, and not before. In any cycle that carries no served read, the read data is zero.
- R8: In a write-write collision, the word afterwards holds the winning port's write data.
- R9: A port whose enable is 0 changes no word, even with its write strobe high. Its read data and dropped flag stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read result, zero when no read is served |
| a_drop | output | 1 | Port A request was discarded by arbitration |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write strobe (1 = write, 0 = read) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read result, zero when no read is served |
| b_drop | output | 1 | Port B request was discarded by arbitration |

## Verification
The bench builds the block with its default sizes: 2 address bits and 4 data bits, which gives four words. With only four words, random two-port traffic produces same-address collisions often, so every collision type and the winner alternation occur many times in a short run. Directed tasks also cover each collision kind, reads of old data, and disabled ports.

// File: rtl/prio_dpram_pkg.sv
package prio_dpram_pkg;

  // Winner selection held by the arbiter
  typedef enum logic {
    PRIO_A = 1'b0,
    PRIO_B = 1'b1
  } prio_e;

endpackage

// File: rtl/prio_dpram_rst_sync.sv
module prio_dpram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/prio_dpram_req_stage.sv
module prio_dpram_req_stage #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              q_en,
  output logic              q_we,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata
);

  logic              en_d;
  logic              we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;

  // A disabled request is squashed so that later stages see a clean idle slot
  always_comb begin
    en_d    = en;
    we_d    = en & we;
    addr_d  = en ? addr  : '0;
    wdata_d = en ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_en    <= 1'b0;
      q_we    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else begin
      q_en    <= en_d;
      q_we    <= we_d;
      q_addr  <= addr_d;
      q_wdata <= wdata_d;
    end
  end

endmodule

// File: rtl/prio_dpram_arbiter.sv
module prio_dpram_arbiter #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              grant_a,
  output logic              grant_b,
  output logic              collide
);

  import prio_dpram_pkg::*;

  prio_e prio_q, prio_d;

  always_comb begin
    collide = a_en & b_en & (a_addr == b_addr) & (a_we | b_we);
    grant_a = a_en & (~collide | (prio_q == PRIO_A));
    grant_b = b_en & (~collide | (prio_q == PRIO_B));
    prio_d  = prio_q;
    if (collide) prio_d = (prio_q == PRIO_A) ? PRIO_B : PRIO_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= PRIO_A;
    else if (collide) prio_q <= prio_d;
  end

endmodule

// File: rtl/prio_dpram_array.sv
module prio_dpram_array #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] ra_addr,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;
  logic [DEPTH-1:0]             word_ce;

  // Arbitration guarantees the two write ports never hit the same word
  always_comb begin
    mem_d   = mem_q;
    word_ce = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wa_en && (wa_addr == ADDR_W'(i))) begin
        mem_d[i]   = wa_data;
        word_ce[i] = 1'b1;
      end else if (wb_en && (wb_addr == ADDR_W'(i))) begin
        mem_d[i]   = wb_data;
        word_ce[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (word_ce[i]) mem_q[i] <= mem_d[i];
      end
    end
  end

  // Reads see the contents before this cycle's writes land
  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];

endmodule

// File: rtl/prio_dpram.sv
module prio_dpram #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_drop,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_drop
);

  localparam int NPORT = 2;

  logic              rst_n_sync;
  logic              s_en    [NPORT];
  logic              s_we    [NPORT];
  logic [ADDR_W-1:0] s_addr  [NPORT];
  logic [DATA_W-1:0] s_wdata [NPORT];
  logic              p_en    [NPORT];
  logic              p_we    [NPORT];
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic [DATA_W-1:0] p_wdata [NPORT];
  logic              grant   [NPORT];
  logic [DATA_W-1:0] rd_raw  [NPORT];
  logic              collide;

  logic [DATA_W-1:0] a_rdata_d, b_rdata_d;
  logic              a_drop_d,  b_drop_d;

  prio_dpram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    p_en[0] = a_en;  p_we[0] = a_we;  p_addr[0] = a_addr;  p_wdata[0] = a_wdata;
    p_en[1] = b_en;  p_we[1] = b_we;  p_addr[1] = b_addr;  p_wdata[1] = b_wdata;
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_stage
    prio_dpram_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .en      (p_en[g]),
      .we      (p_we[g]),
      .addr    (p_addr[g]),
      .wdata   (p_wdata[g]),
      .q_en    (s_en[g]),
      .q_we    (s_we[g]),
      .q_addr  (s_addr[g]),
      .q_wdata (s_wdata[g])
    );
  end

  prio_dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .a_en    (s_en[0]),
    .a_we    (s_we[0]),
    .a_addr  (s_addr[0]),
    .b_en    (s_en[1]),
    .b_we    (s_we[1]),
    .b_addr  (s_addr[1]),
    .grant_a (grant[0]),
    .grant_b (grant[1]),
    .collide (collide)
  );

  prio_dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wa_en   (grant[0] & s_we[0]),
    .wa_addr (s_addr[0]),
    .wa_data (s_wdata[0]),
    .wb_en   (grant[1] & s_we[1]),
    .wb_addr (s_addr[1]),
    .wb_data (s_wdata[1]),
    .ra_addr (s_addr[0]),
    .rb_addr (s_addr[1]),
    .ra_data (rd_raw[0]),
    .rb_data (rd_raw[1])
  );

  always_comb begin
    a_rdata_d = (grant[0] && !s_we[0]) ? rd_raw[0] : '0;
    b_rdata_d = (grant[1] && !s_we[1]) ? rd_raw[1] : '0;
    a_drop_d  = s_en[0] & ~grant[0];
    b_drop_d  = s_en[1] & ~grant[1];
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      a_rdata <= '0;
      b_rdata <= '0;
      a_drop  <= 1'b0;
      b_drop  <= 1'b0;
    end else begin
      a_rdata <= a_rdata_d;
      b_rdata <= b_rdata_d;
      a_drop  <= a_drop_d;
      b_drop  <= b_drop_d;
    end
  end

endmodule

// File: rtl/prio_dpram_checker.sv
module prio_dpram_checker #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_en,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_en,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] a_rdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic              a_drop,
  input logic              b_drop
);

  // Expected loser of the next collision: B first after reset
  logic exp_b_loses_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 exp_b_loses_q <= 1'b1;
    else if (a_drop || b_drop)  exp_b_loses_q <= ~exp_b_loses_q;
  end

  p_drop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drop |-> a_rdata == '0) and (b_drop |-> b_rdata == '0));

  p_single_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drop && b_drop));

  p_drop_needs_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drop || b_drop) |-> ($past(a_en, 2) && $past(b_en, 2) &&
                            $past(a_addr, 2) == $past(b_addr, 2) &&
                            ($past(a_we, 2) || $past(b_we, 2))));

  p_split_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && b_en && a_addr != b_addr) |-> ##2 (!a_drop && !b_drop));

  p_dual_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && b_en && !a_we && !b_we) |-> ##2 (!a_drop && !b_drop));

  p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drop || b_drop) |-> (b_drop == exp_b_loses_q));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |-> ##2 (!a_drop && a_rdata == '0));

endmodule

bind prio_dpram prio_dpram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .a_en    (a_en),
  .a_we    (a_we),
  .a_addr  (a_addr),
  .b_en    (b_en),
  .b_we    (b_we),
  .b_addr  (b_addr),
  .a_rdata (a_rdata),
  .b_rdata (b_rdata),
  .a_drop  (a_drop),
  .b_drop  (b_drop)
);

// File: tb/prio_dpram_bench.sv
module prio_dpram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              a_en, a_we, b_en, b_we;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic              a_drop, b_drop;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] mdl [DEPTH];
  bit                mdl_prio_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_prio_dpram (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_drop(a_drop),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_drop(b_drop)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
  endtask

  // One request pair, followed through the pipeline against the model
  task automatic do_op(input bit ae, input bit awe, input int aad, input int awd,
                       input bit be, input bit bwe, input int bad, input int bwd,
                       input string req);
    bit clash, ga, gb;
    int ea, eb;
    clash = ae && be && aad == bad && (awe || bwe);
    ga = ae && (!clash || !mdl_prio_b);
    gb = be && (!clash ||  mdl_prio_b);
    ea = (ga && !awe) ? int'(mdl[aad]) : 0;
    eb = (gb && !bwe) ? int'(mdl[bad]) : 0;
    if (ga && awe) mdl[aad] = DATA_W'(awd);
    if (gb && bwe) mdl[bad] = DATA_W'(bwd);
    if (clash) mdl_prio_b = !mdl_prio_b;

    @(negedge clk);
    a_en = ae; a_we = awe; a_addr = ADDR_W'(aad); a_wdata = DATA_W'(awd);
    b_en = be; b_we = bwe; b_addr = ADDR_W'(bad); b_wdata = DATA_W'(bwd);
    @(posedge clk);
    @(negedge clk);
    drive_idle();
    check({req, " R7 no early A"}, int'(a_rdata) + int'(a_drop), 0);
    check({req, " R7 no early B"}, int'(b_rdata) + int'(b_drop), 0);
    @(posedge clk);
    @(negedge clk);
    check({req, " A rdata"}, int'(a_rdata), ea);
    check({req, " B rdata"}, int'(b_rdata), eb);
    check({req, " A drop"},  int'(a_drop), int'(ae && !ga));
    check({req, " B drop"},  int'(b_drop), int'(be && !gb));
    @(posedge clk);
    @(negedge clk);
    check({req, " R7 one-cycle"}, int'(a_rdata) + int'(b_rdata) + int'(a_drop) + int'(b_drop), 0);
  endtask

  task automatic t_reset();
    check("R1 a_rdata at reset", int'(a_rdata), 0);
    check("R1 drops at reset", int'(a_drop) + int'(b_drop), 0);
    for (int i = 0; i < DEPTH; i++) begin
      check("R1 word zero", int'(mdl[i]), 0);
      do_op(1, 0, i, 0, 1, 0, (i + 1) % DEPTH, 0, "R1 read after reset");
    end
  endtask

  task automatic t_diff_addr();
    do_op(1, 1, 1, 5, 1, 1, 2, 10, "R2 dual write");
    do_op(1, 0, 2, 0, 1, 0, 1, 0,  "R2 dual read");
    check("R2 word1 stored", int'(mdl[1]), 5);
    do_op(1, 0, 1, 0, 1, 1, 3, 7,  "R2 read+write");
    do_op(1, 1, 0, 9, 1, 0, 3, 0,  "R2 write+read");
  endtask

  task automatic t_read_read();
    do_op(1, 0, 1, 0, 1, 0, 1, 0, "R3 same addr read");
    do_op(1, 0, 2, 0, 1, 0, 3, 0, "R3 diff addr read");
    check("R3 prio unchanged", int'(mdl_prio_b), 0);
  endtask

  task automatic t_first_conflict();
    // First collision after reset: A (writer) wins, B (reader) dropped
    do_op(1, 1, 2, 4'hC, 1, 0, 2, 0, "R5 A wins first / R4 writer wins");
    do_op(1, 0, 2, 0, 0, 0, 0, 0, "R4 readback");
    check("R4 word2 written", int'(mdl[2]), 12);
  endtask

  task automatic t_reader_wins();
    // Now B holds priority; B reads while A writes the same word
    do_op(1, 1, 2, 4'h3, 1, 0, 2, 0, "R6 reader wins old value");
    do_op(0, 0, 0, 0, 1, 0, 2, 0, "R6 word unchanged");
    check("R6 model word2", int'(mdl[2]), 12);
  endtask

  task automatic t_write_write();
    do_op(1, 1, 3, 4'h1, 1, 1, 3, 4'h6, "R8 ww A wins");
    do_op(1, 0, 3, 0, 0, 0, 0, 0, "R8 readback 1");
    do_op(1, 1, 3, 4'h2, 1, 1, 3, 4'hE, "R8 ww B wins");
    do_op(0, 0, 0, 0, 1, 0, 3, 0, "R8 readback 2");
    check("R8 word3 from B", int'(mdl[3]), 14);
    do_op(1, 1, 0, 4'h5, 1, 1, 0, 4'h8, "R5 alternation");
  endtask

  task automatic t_disabled();
    do_op(0, 1, 1, 4'hF, 0, 1, 2, 4'hF, "R9 disabled writes");
    do_op(1, 0, 1, 0, 1, 0, 2, 0, "R9 words unchanged");
    check("R9 word1", int'(mdl[1]), 5);
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      do_op(1'($urandom), 1'($urandom), int'($urandom % DEPTH), int'($urandom % 16),
            1'($urandom), 1'($urandom), int'($urandom % DEPTH), int'($urandom % 16),
            "R4 random traffic");
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    mdl_prio_b = 0;
    drive_idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_diff_addr();
    t_read_read();
    t_first_conflict();
    t_reader_wins();
    t_write_write();
    t_disabled();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule